// File: doc/BRIEF.md
# DRAM Cycle Decoder with Latched Parallel Test Mode

This block sits on the device side of a dynamic memory, between a sampler that turns the row strobe, column strobe and write enable into clean clocked levels and a model of the memory array. It watches the strobes and the multiplexed address pins, one sample per clock. It decides what each period of low row strobe is: a normal read or write (with any number of column accesses, as in page mode), a refresh of an external row, a refresh of an internal counter row started by column-before-row strobe order, a hidden refresh that keeps read data on the pin, or the write-qualified column-before-row cycle that enters test mode.

Toward the array the block gives the latched row, the latched column and one-cycle read and write strobes with a write mask of eight grouped bits. On reads it chooses the output bit. In test mode it reduces the eight grouped bits to one pass/fail bit. The test mode flag is latched and stays set until a refresh cycle of the external-row or counter type ends. At the end of each cycle a one-cycle pulse and a type code report what the cycle was.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, every output is cleared to zero: no strobe, no done pulse, test_mode 0, dout_oe 0, addresses 0. The refresh counter restarts at row 0.
- R2: A cycle whose row strobe falls while the column strobe is high, and that sees no column strobe fall before the row strobe rises, is reported as type 3 (external-row refresh). row_addr holds the addr value sampled at the row strobe fall.
- R3: A column strobe fall with we_n high, during a cycle that started with the column strobe high, gives rd_en for exactly one cycle. In the next cycle it gives dout = rd_bits[col_addr[2:0]] with dout_oe high. dout_oe drops in the cycle after cas_n is sampled high. If the first column access of the cycle is a read, the cycle type is 1.
- R4: The same column strobe fall with we_n low gives wr_en for one cycle. wr_mask has only bit addr[2:0] set and wr_data repeats din in all 8 bits. If the first column access is a write, the cycle type is 2.
- R5: cyc_done is high for exactly one cycle. It is high in the cycle after the first sample with ras_n high following a low period, and cyc_type then carries the finished cycle's code.
- R6: Column strobe low and we_n high when the row strobe falls, with no read data held, gives type 4 (counter refresh). row_addr is the internal counter value, and the cycle makes no column access.
- R7: The internal row counter covers 2048 rows. It advances by one at the end of each type 4 or type 5 cycle and wraps from 2047 to 0.
- R8: Column strobe held low from a prior read (dout_oe high) with we_n high when the row strobe falls gives type 5 (hidden refresh). It uses the counter row, and dout and dout_oe stay unchanged throughout.
- R9: Column strobe and we_n both low when the row strobe falls gives type 6. test_mode sets at the end of that cycle and stays set through any number of read and write cycles.
- R10: test_mode clears at the end of a type 3, type 4 or type 5 cycle.
- R11: In test mode a read gives dout = 1 when all 8 rd_bits are equal and 0 when any differs. Column address bits [2:0] are ignored: col_addr[2:0] is forced to 0 and dout does not depend on them.
- R12: In test mode a write sets all 8 bits of wr_mask and repeats din in all 8 bits of wr_data.
- R13: Every column strobe fall inside one row strobe low period of a type 1 or 2 cycle performs its own access. rd_en and wr_en are never high together, and neither is high without the row strobe low in the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| rd_bits | input | 8 | Eight grouped bits returned by the array for the current row/column |
| row_addr | output | 11 | Row latched at the row strobe fall (external or counter) |
| col_addr | output | 11 | Column latched at the column strobe fall, low 3 bits zero in test mode |
| rd_en | output | 1 | One-cycle array read strobe |
| wr_en | output | 1 | One-cycle array write strobe |
| wr_mask | output | 8 | Which grouped bits the write updates |
| wr_data | output | 8 | Write data for the grouped bits |
| dout | output | 1 | Read data or test pass/fail bit |
| dout_oe | output | 1 | Output drive enable |
| test_mode | output | 1 | Latched parallel test mode flag |
| cyc_done | output | 1 | One-cycle pulse when a cycle ends |
| cyc_type | output | 3 | Code of the finished cycle (1 read, 2 write, 3 ext refresh, 4 counter refresh, 5 hidden, 6 test entry) |

## Verification
On every clock the assertions check that the done pulse lasts one cycle and follows a rising row strobe. They also check that read and write strobes never overlap and only happen inside a cycle, and that write masks are one-hot in normal mode and full in test mode. Further checks are that column bits [2:0] are zero on test accesses, that the test flag changes only with a done pulse and only on the cycle types allowed to set or clear it, and that the output lets go after the column strobe rises. Only the bench scenarios can show that each strobe ordering gets the right classification, that the counter steps through all 2048 rows and wraps, that read data survives a hidden refresh, and that the pass/fail reduction gives the right value. A behavioural reference model compared every clock covers those points.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM cycle decoder.
// Assumes: cycle codes are fixed, since software and the array model decode them.
package dcd_pkg;
    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_READ   = 3'd1,
        CYC_WRITE  = 3'd2,
        CYC_EXTREF = 3'd3,
        CYC_CNTREF = 3'd4,
        CYC_HIDDEN = 3'd5,
        CYC_TSTENT = 3'd6
    } cyc_t;
endpackage

// File: rtl/dcd_strobe_classifier.sv
`timescale 1ns/1ps
// Classifies each row-strobe-low period from the order of strobe edges.
// Assumes: strobes arrive already synchronous to clk; an edge is seen by
// comparing the current sample with the one before it. Column strobe low in
// the same sample as the row strobe fall counts as column-before-row.
module dcd_strobe_classifier
    import dcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic out_held,
    output logic ras_fall,
    output logic ras_end,
    output logic acc_rd,
    output logic acc_wr,
    output cyc_t cur_type,
    output logic cyc_done,
    output cyc_t cyc_type
);
    logic ras_q;
    logic cas_q;
    logic can_access;
    logic col_strobe;

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall   = ras_q & ~ras_n;
    assign ras_end    = ~ras_q & ras_n;
    assign can_access = (cur_type == CYC_EXTREF) || (cur_type == CYC_READ) ||
                        (cur_type == CYC_WRITE);
    assign col_strobe = ~ras_q & ~ras_n & cas_q & ~cas_n & can_access;
    assign acc_rd     = col_strobe & we_n;
    assign acc_wr     = col_strobe & ~we_n;

    // Decide the cycle kind from strobe levels at the row strobe fall.
    function automatic cyc_t classify(input logic c_n, input logic w_n, input logic held);
        if (c_n)       return CYC_EXTREF;
        else if (!w_n) return CYC_TSTENT;
        else if (held) return CYC_HIDDEN;
        else           return CYC_CNTREF;
    endfunction

    // Current cycle kind: set at the fall, refined by the first column access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_type <= CYC_NONE;
        end else if (ras_fall) begin
            cur_type <= classify(cas_n, we_n, out_held);
        end else if (col_strobe && cur_type == CYC_EXTREF) begin
            cur_type <= we_n ? CYC_READ : CYC_WRITE;
        end
    end

    // End-of-cycle report: one-cycle pulse plus the finished cycle's code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_done <= 1'b0;
            cyc_type <= CYC_NONE;
        end else begin
            cyc_done <= ras_end;
            if (ras_end) begin
                cyc_type <= cur_type;
            end
        end
    end
endmodule

// File: rtl/dcd_refresh_counter.sv
`timescale 1ns/1ps
// Internal refresh row counter for column-before-row cycles.
// Assumes: advance is a single-cycle pulse; ROWS need not be a power of two.
module dcd_refresh_counter #(
    parameter int ROWS = 2048,
    localparam int CW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [CW-1:0] count
);
    // Step the row pointer, wrapping after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (advance) begin
            count <= (count == CW'(ROWS - 1)) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/dcd_test_flag.sv
`timescale 1ns/1ps
// Latched parallel test mode flag.
// Assumes: set and clear never arrive together (they come from distinct cycle kinds).
module dcd_test_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    // Hold the mode until an exit cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clr_i) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dcd_access_path.sv
`timescale 1ns/1ps
// Address latching, array strobes, write masking and read reduction.
// Assumes: the array answers rd_bits combinationally for the latched row and
// column while rd_en is high; GROUP is a power of two and ADDR_W >= CW.
module dcd_access_path #(
    parameter int ADDR_W = 11,
    parameter int GROUP  = 8,
    parameter int CW     = 11,
    localparam int SEL_W = $clog2(GROUP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              test_mode,
    input  logic              cas_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     count,
    input  logic [GROUP-1:0]  rd_bits,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [GROUP-1:0]  wr_mask,
    output logic [GROUP-1:0]  wr_data,
    output logic              dout,
    output logic              dout_oe
);
    logic [GROUP-1:0] sel_onehot;
    logic             all_same;
    logic             picked;

    // Decode the low column bits into a one-hot location select.
    for (genvar g = 0; g < GROUP; g++) begin : g_sel
        assign sel_onehot[g] = (addr[SEL_W-1:0] == SEL_W'(g));
    end

    assign all_same = (&rd_bits) | ~(|rd_bits);
    assign picked   = rd_bits[col_addr[SEL_W-1:0]];

    // Row latch: external address, or counter row when the column strobe led.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr <= '0;
        end else if (ras_fall) begin
            row_addr <= cas_n ? addr : ADDR_W'(count);
        end
    end

    // Column latch and array strobes for each column access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_addr <= '0;
            rd_en    <= 1'b0;
            wr_en    <= 1'b0;
            wr_mask  <= '0;
            wr_data  <= '0;
        end else begin
            rd_en <= acc_rd;
            wr_en <= acc_wr;
            if (acc_rd || acc_wr) begin
                col_addr <= test_mode ? {addr[ADDR_W-1:SEL_W], SEL_W'(0)} : addr;
            end
            if (acc_wr) begin
                wr_mask <= test_mode ? {GROUP{1'b1}} : sel_onehot;
                wr_data <= {GROUP{din}};
            end
        end
    end

    // Output bit: picked or reduced read data, released when the column strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (cas_n) begin
            dout_oe <= 1'b0;
        end else if (rd_en) begin
            dout_oe <= 1'b1;
            dout    <= test_mode ? all_same : picked;
        end
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
// Top of the DRAM cycle decoder: classifies strobe cycles, drives array
// accesses and refreshes, and runs the latched parallel test mode.
// Assumes: strobes are pre-sampled on clk by an upstream sampler.
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int GROUP    = 8,
    parameter int REF_ROWS = 2048,
    localparam int CW      = $clog2(REF_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic [GROUP-1:0]  rd_bits,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [GROUP-1:0]  wr_mask,
    output logic [GROUP-1:0]  wr_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              test_mode,
    output logic              cyc_done,
    output logic [2:0]        cyc_type
);
    logic          ras_fall;
    logic          ras_end;
    logic          acc_rd;
    logic          acc_wr;
    cyc_t          cur_type;
    cyc_t          done_type;
    logic [CW-1:0] ref_count;
    logic          is_cnt_ref;
    logic          tm_set;
    logic          tm_clr;

    dcd_strobe_classifier u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .out_held (dout_oe),
        .ras_fall (ras_fall),
        .ras_end  (ras_end),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .cur_type (cur_type),
        .cyc_done (cyc_done),
        .cyc_type (done_type)
    );

    assign is_cnt_ref = (cur_type == CYC_CNTREF) || (cur_type == CYC_HIDDEN);
    assign tm_set     = ras_end && (cur_type == CYC_TSTENT);
    assign tm_clr     = ras_end && (is_cnt_ref || cur_type == CYC_EXTREF);

    dcd_refresh_counter #(.ROWS(REF_ROWS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ras_end && is_cnt_ref),
        .count   (ref_count)
    );

    dcd_test_flag u_tm (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tm_set),
        .clr_i (tm_clr),
        .flag  (test_mode)
    );

    dcd_access_path #(.ADDR_W(ADDR_W), .GROUP(GROUP), .CW(CW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_fall  (ras_fall),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .test_mode (test_mode),
        .cas_n     (cas_n),
        .din       (din),
        .addr      (addr),
        .count     (ref_count),
        .rd_bits   (rd_bits),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign cyc_type = done_type;
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
// Protocol checker for the DRAM cycle decoder, bound to its top.
// Assumes: it is only ever connected through the bind below.
module dcd_checker #(
    parameter int ADDR_W = 11,
    parameter int GROUP  = 8,
    localparam int SEL_W = $clog2(GROUP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [GROUP-1:0]  wr_mask,
    input logic [GROUP-1:0]  wr_data,
    input logic [ADDR_W-1:0] col_addr,
    input logic              test_mode,
    input logic              dout_oe,
    input logic              cyc_done,
    input logic [2:0]        cyc_type
);
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    p_done_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> ($past(ras_n) && !$past(ras_n, 2)));

    p_rw_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_access_in_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> !$past(ras_n));

    p_norm_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !test_mode) |-> ($countones(wr_mask) == 1 && wr_mask[col_addr[SEL_W-1:0]]));

    p_test_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && test_mode) |-> (wr_mask == {GROUP{1'b1}} &&
                                  (wr_data == {GROUP{1'b1}} || wr_data == {GROUP{1'b0}})));

    p_test_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && test_mode) |-> (col_addr[SEL_W-1:0] == '0));

    p_test_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_mode) |-> cyc_done);

    p_test_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (cyc_type == 3'd6));

    p_test_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cyc_type == 3'd3 || cyc_type == 3'd4 || cyc_type == 3'd5));

    p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n) |-> !dout_oe);
endmodule

bind dram_cycle_decoder dcd_checker #(.ADDR_W(ADDR_W), .GROUP(GROUP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .col_addr  (col_addr),
    .test_mode (test_mode),
    .dout_oe   (dout_oe),
    .cyc_done  (cyc_done),
    .cyc_type  (cyc_type)
);

// File: tb/dram_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed strobe scenarios plus a behavioural
// reference model compared against the outputs on every clock.
module dram_cycle_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [10:0] addr = '0;
    logic        din = 1'b0;
    logic [7:0]  rd_bits = '0;
    logic [10:0] row_addr;
    logic [10:0] col_addr;
    logic        rd_en;
    logic        wr_en;
    logic [7:0]  wr_mask;
    logic [7:0]  wr_data;
    logic        dout;
    logic        dout_oe;
    logic        test_mode;
    logic        cyc_done;
    logic [2:0]  cyc_type;

    int checks = 0;
    int errors = 0;
    int ncnt   = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .rd_bits(rd_bits), .row_addr(row_addr),
        .col_addr(col_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .dout(dout), .dout_oe(dout_oe), .test_mode(test_mode),
        .cyc_done(cyc_done), .cyc_type(cyc_type)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ras_q, m_cas_q, m_type, m_cnt, m_test, m_row, m_col;
    int m_rd, m_wr, m_mask, m_wdata, m_dout, m_oe, m_done, m_dtype;
    int o_oe, o_test, o_type;
    bit fell, rose, colacc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ras_q = 1; m_cas_q = 1; m_type = 0; m_cnt = 0; m_test = 0;
            m_row = 0; m_col = 0; m_rd = 0; m_wr = 0; m_mask = 0; m_wdata = 0;
            m_dout = 0; m_oe = 0; m_done = 0; m_dtype = 0;
        end else begin
            o_oe = m_oe; o_test = m_test; o_type = m_type;
            fell   = (m_ras_q == 1) && !ras_n;
            rose   = (m_ras_q == 0) && ras_n;
            colacc = (m_ras_q == 0) && !ras_n && (m_cas_q == 1) && !cas_n &&
                     (o_type == 1 || o_type == 2 || o_type == 3);
            if (cas_n) m_oe = 0;
            else if (m_rd == 1) begin
                m_oe = 1;
                m_dout = (o_test == 1) ? int'(rd_bits == 8'hFF || rd_bits == 8'h00)
                                       : int'(rd_bits[m_col % 8]);
            end
            m_rd = int'(colacc && we_n);
            m_wr = int'(colacc && !we_n);
            if (colacc) begin
                m_col = (o_test == 1) ? (int'(addr) & ~7) : int'(addr);
                if (!we_n) begin
                    m_mask  = (o_test == 1) ? 255 : (1 << (int'(addr) % 8));
                    m_wdata = din ? 255 : 0;
                end
                if (o_type == 3) m_type = we_n ? 1 : 2;
            end
            m_done = int'(rose);
            if (rose) begin
                m_dtype = o_type;
                if (o_type == 6) m_test = 1;
                else if (o_type >= 3 && o_type <= 5) m_test = 0;
                if (o_type == 4 || o_type == 5) m_cnt = (m_cnt + 1) % 2048;
            end
            if (fell) begin
                m_row  = cas_n ? int'(addr) : m_cnt;
                m_type = cas_n ? 3 : (!we_n ? 6 : ((o_oe == 1) ? 5 : 4));
            end
            m_ras_q = int'(ras_n);
            m_cas_q = int'(cas_n);
        end
    end

    // Compare model and outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R5 cyc_done", int'(cyc_done), m_done);
            if (m_done == 1) chk("R2 cyc_type", int'(cyc_type), m_dtype);
            chk("R9 test_mode", int'(test_mode), m_test);
            chk("R3 rd_en", int'(rd_en), m_rd);
            chk("R4 wr_en", int'(wr_en), m_wr);
            if (m_wr == 1) begin
                chk("R4 wr_mask", int'(wr_mask), m_mask);
                chk("R12 wr_data", int'(wr_data), m_wdata);
            end
            if (m_rd == 1 || m_wr == 1) chk("R11 col_addr", int'(col_addr), m_col);
            chk("R8 dout_oe", int'(dout_oe), m_oe);
            if (m_oe == 1) chk("R3 dout", int'(dout), m_dout);
            chk("R6 row_addr", int'(row_addr), m_row);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic r, input logic c, input logic w, input logic [10:0] a);
        ras_n = r; cas_n = c; we_n = w; addr = a;
        @(negedge clk);
    endtask

    task automatic end_cycle(input logic hold_cas, input int exp_type, input string tag);
        drive(1'b1, hold_cas ? 1'b0 : 1'b1, 1'b1, '0);
        chk(tag, {cyc_done, cyc_type}, 8 | exp_type);
        drive(1'b1, hold_cas ? 1'b0 : 1'b1, 1'b1, '0);
    endtask

    task automatic read_cycle(input logic [10:0] row, input logic [10:0] col,
                              input int exp, input string tag);
        drive(1'b0, 1'b1, 1'b1, row);
        drive(1'b0, 1'b0, 1'b1, col);
        drive(1'b0, 1'b0, 1'b1, col);
        chk(tag, int'(dout), exp);
    endtask

    task automatic cnt_refresh();
        drive(1'b1, 1'b0, 1'b1, 11'h7FF);
        drive(1'b0, 1'b0, 1'b1, 11'h7FF);
        chk("R7 counter row", int'(row_addr), ncnt % 2048);
        drive(1'b0, 1'b0, 1'b1, '0);
        end_cycle(1'b0, 4, "R6 type counter refresh");
        ncnt++;
    endtask

    task automatic test_entry();
        drive(1'b1, 1'b0, 1'b0, '0);
        drive(1'b0, 1'b0, 1'b0, '0);
        drive(1'b0, 1'b0, 1'b0, '0);
        end_cycle(1'b0, 6, "R9 type test entry");
        chk("R9 test set", int'(test_mode), 1);
    endtask

    task automatic ext_refresh(input logic [10:0] row);
        drive(1'b0, 1'b1, 1'b1, row);
        drive(1'b0, 1'b1, 1'b1, '0);
        chk("R2 ext row", int'(row_addr), int'(row));
        end_cycle(1'b0, 3, "R2 type ext refresh");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(cyc_done), 0);
        chk("R1 reset test", int'(test_mode), 0);
        chk("R1 reset oe", int'(dout_oe), 0);
        chk("R1 reset strobes", int'({rd_en, wr_en}), 0);
        chk("R1 reset row", int'(row_addr), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // Normal reads with two bit patterns.
        rd_bits = 8'b0010_0000;
        read_cycle(11'h123, 11'h045, 1, "R3 read picks bit 5");
        end_cycle(1'b0, 1, "R3 type read");
        rd_bits = 8'hDF;
        read_cycle(11'h124, 11'h045, 0, "R3 read picks bit 5 low");
        end_cycle(1'b0, 1, "R3 type read");

        // Normal write.
        din = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 11'h007);
        drive(1'b0, 1'b0, 1'b0, 11'h00A);
        chk("R4 mask one-hot", int'(wr_mask), 8'h04);
        chk("R4 data repeated", int'(wr_data), 8'hFF);
        drive(1'b0, 1'b1, 1'b1, '0);
        end_cycle(1'b0, 2, "R4 type write");

        // Page mode: two column accesses in one row period.
        rd_bits = 8'h02;
        read_cycle(11'h050, 11'h001, 1, "R13 first page access");
        drive(1'b0, 1'b1, 1'b1, '0);
        drive(1'b0, 1'b0, 1'b1, 11'h003);
        drive(1'b0, 1'b0, 1'b1, 11'h003);
        chk("R13 second page access", int'(dout), 0);
        end_cycle(1'b0, 1, "R13 type page read");

        // External-row refresh and counter refreshes.
        ext_refresh(11'h2AA);
        repeat (3) cnt_refresh();

        // Hidden refresh: read data held across a counter refresh.
        rd_bits = 8'h80;
        read_cycle(11'h011, 11'h007, 1, "R8 read before hidden");
        end_cycle(1'b1, 1, "R8 read end with cas held");
        drive(1'b0, 1'b0, 1'b1, '0);
        chk("R8 hidden row", int'(row_addr), ncnt);
        chk("R8 oe held", int'(dout_oe), 1);
        rd_bits = 8'h00;
        drive(1'b0, 1'b0, 1'b1, '0);
        chk("R8 dout held", int'(dout), 1);
        end_cycle(1'b1, 5, "R8 type hidden");
        ncnt++;
        drive(1'b1, 1'b1, 1'b1, '0);
        chk("R3 oe released", int'(dout_oe), 0);

        // Test mode entry, reads and writes.
        test_entry();
        rd_bits = 8'hFF;
        drive(1'b0, 1'b1, 1'b1, 11'h033);
        drive(1'b0, 1'b0, 1'b1, 11'h015);
        chk("R11 low col bits ignored", int'(col_addr), 11'h010);
        drive(1'b0, 1'b0, 1'b1, 11'h015);
        chk("R11 all ones pass", int'(dout), 1);
        end_cycle(1'b0, 1, "R9 read in test mode");
        rd_bits = 8'h00;
        read_cycle(11'h033, 11'h012, 1, "R11 all zeros pass");
        end_cycle(1'b0, 1, "R9 read in test mode");
        rd_bits = 8'hF7;
        read_cycle(11'h033, 11'h013, 0, "R11 one bit differs");
        end_cycle(1'b0, 1, "R9 read in test mode");
        din = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 11'h034);
        drive(1'b0, 1'b0, 1'b0, 11'h006);
        chk("R12 full mask", int'(wr_mask), 8'hFF);
        chk("R12 data", int'(wr_data), 8'hFF);
        drive(1'b0, 1'b1, 1'b1, '0);
        end_cycle(1'b0, 2, "R12 type write");
        chk("R9 test stays", int'(test_mode), 1);

        // Exits: external-row refresh, then counter refresh.
        ext_refresh(11'h100);
        chk("R10 cleared by ext refresh", int'(test_mode), 0);
        test_entry();
        cnt_refresh();
        chk("R10 cleared by counter refresh", int'(test_mode), 0);

        // Walk the counter through its wrap.
        while (ncnt < 2050) cnt_refresh();

        drive(1'b1, 1'b1, 1'b1, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule